// File: doc/BRIEF.md
# Single-Bit MRU Pseudo-LRU Replacement State

This block holds the replacement state of one set of a set-associative cache, with one most-recently-used flag per way. Every access to a way, whether a hit or a fill after a miss, sets that way's flag. When setting it would leave every flag of the set at one, the accessed way keeps its flag and all the others drop to zero. The eviction candidate is the lowest-numbered way whose flag is zero. It is an approximation of LRU that needs only one bit per way.

The cache controller drives an access strobe with the way that was touched. It raises a lookup request whenever it needs a way to fill. A per-way valid mask lets empty ways be filled before any flag is consulted; this rule can be removed through a parameter. The victim output is combinational from the stored flags, so a lookup made in the same cycle as an access sees the state from before that access. A wrapper can repeat this block across sets by keeping the flag vector in an indexed state RAM. The set index is taken from physical address bits 6 to 16.

Top module: `mru_repl_set`

## Requirements
- R1: While reset is asserted and after it is released, all flags read zero and the victim is way 0.
- R2: An access with an in-range way index sets that way's flag on the next clock edge. The other flags stay as they were unless R3 applies.
- R3: If an access would make all flags one, then after the edge only the accessed way's flag is one.
- R4: When every way is valid (valid mask bit = 1), the victim is the lowest-numbered way whose flag is zero.
- R5: When some way is invalid (valid mask bit = 0), the victim is the lowest-numbered invalid way, whatever the flags are.
- R6: An access and a lookup in the same cycle report the victim computed from the flags before that access.
- R7: A cycle without an access, or an access whose way index is at or above the number of ways, leaves the flags unchanged.
- R8: The victim-valid output equals the lookup request in the same cycle.
- R9: A cyclic sweep of 13 distinct addresses through one 12-way set produces the hit and miss sequence that the R2 to R5 rules predict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_vld | input | 1 | Access strobe (hit or fill) |
| acc_way | input | WIDX | Way touched by the access |
| valid_mask | input | WAYS | Per-way valid bits, 1 = holds a line |
| lkp_req | input | 1 | Lookup request for a victim |
| victim_vld | output | 1 | Victim output is meaningful |
| victim_way | output | WIDX | Way to evict next |
| mru_bits | output | WAYS | Current MRU flag vector |

## Verification
A pseudo-random walk of way indices includes indices 12 to 15, which are out of range. Most cycles have a full valid mask and some have scattered holes in it. This walk separates the plain set rule from the wrap-around clear and shows whether out-of-range indices are ignored. A directed fill of ways 0 to 11 in order must wipe the set on the last fill, which catches a clear that fires one access early or late. A cyclic 13-address sweep starts from an empty set and uses a bench cache model, so the invalid-first fills and the later flag-driven evictions both decide the hit and miss pattern. Lookups issued alongside accesses tell apart a victim taken before the update from one taken after it.

// File: rtl/mru_repl_pkg.sv
package mru_repl_pkg;

   // Upper bound on associativity supported by the shared helpers.
   localparam int unsigned REPL_MAX_WAYS = 32;

   // Index of the lowest set bit; 0 when the vector is empty.
   function automatic int unsigned lowest_one(input logic [REPL_MAX_WAYS-1:0] vec);
      int unsigned idx;
      idx = 0;
      for (int i = REPL_MAX_WAYS - 1; i >= 0; i--) begin
         if (vec[i]) idx = i;
      end
      return idx;
   endfunction

endpackage

// File: rtl/mru_next_state.sv
module mru_next_state #(
   parameter int unsigned WAYS = 12,
   parameter int unsigned WIDX = $clog2(WAYS)
) (
   input  logic [WAYS-1:0] cur_bits,
   input  logic            acc_vld,
   input  logic [WIDX-1:0] acc_way,
   output logic [WAYS-1:0] nxt_bits
);

   logic            way_in_range;
   logic [WAYS-1:0] touch_mask;
   logic [WAYS-1:0] merged;

   generate
      if (WAYS == (1 << WIDX)) begin : g_full_range
         assign way_in_range = 1'b1;
      end else begin : g_part_range
         assign way_in_range = (int'(acc_way) < int'(WAYS));
      end
   endgenerate

   always_comb begin
      touch_mask = '0;
      for (int i = 0; i < int'(WAYS); i++) begin
         touch_mask[i] = (int'(acc_way) == i);
      end
      merged = cur_bits | touch_mask;
      if (!acc_vld || !way_in_range) begin
         nxt_bits = cur_bits;
      end else if (&merged) begin
         nxt_bits = touch_mask;
      end else begin
         nxt_bits = merged;
      end
   end

endmodule

// File: rtl/mru_victim_pick.sv
module mru_victim_pick
   import mru_repl_pkg::*;
#(
   parameter int unsigned WAYS          = 12,
   parameter int unsigned WIDX          = $clog2(WAYS),
   parameter bit          INVALID_FIRST = 1'b1
) (
   input  logic [WAYS-1:0] cur_bits,
   input  logic [WAYS-1:0] valid_mask,
   output logic [WIDX-1:0] victim_way
);

   logic [REPL_MAX_WAYS-1:0] clear_vec;
   logic [WIDX-1:0]          by_flag;

   always_comb begin
      clear_vec = '0;
      clear_vec[WAYS-1:0] = ~cur_bits;
      by_flag = WIDX'(lowest_one(clear_vec));
   end

   generate
      if (INVALID_FIRST) begin : g_inv_first
         logic [REPL_MAX_WAYS-1:0] empty_vec;
         logic [WIDX-1:0]          by_empty;
         always_comb begin
            empty_vec = '0;
            empty_vec[WAYS-1:0] = ~valid_mask;
            by_empty = WIDX'(lowest_one(empty_vec));
            victim_way = (&valid_mask) ? by_flag : by_empty;
         end
      end else begin : g_flag_only
         logic unused_mask;
         assign unused_mask = ^valid_mask;
         assign victim_way  = by_flag;
      end
   endgenerate

endmodule

// File: rtl/mru_repl_set.sv
module mru_repl_set
   import mru_repl_pkg::*;
#(
   parameter int unsigned WAYS          = 12,
   parameter bit          INVALID_FIRST = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    acc_vld,
   input  logic [$clog2(WAYS)-1:0] acc_way,
   input  logic [WAYS-1:0]         valid_mask,
   input  logic                    lkp_req,
   output logic                    victim_vld,
   output logic [$clog2(WAYS)-1:0] victim_way,
   output logic [WAYS-1:0]         mru_bits
);

   localparam int unsigned WIDX = $clog2(WAYS);

   generate
      if (WAYS < 2 || WAYS > REPL_MAX_WAYS) begin : g_bad_ways
         $error("mru_repl_set: WAYS out of supported range");
      end
   endgenerate

   logic [WAYS-1:0] state_q;
   logic [WAYS-1:0] state_d;

   mru_next_state #(
      .WAYS (WAYS),
      .WIDX (WIDX)
   ) i_next (
      .cur_bits (state_q),
      .acc_vld  (acc_vld),
      .acc_way  (acc_way),
      .nxt_bits (state_d)
   );

   mru_victim_pick #(
      .WAYS          (WAYS),
      .WIDX          (WIDX),
      .INVALID_FIRST (INVALID_FIRST)
   ) i_pick (
      .cur_bits   (state_q),
      .valid_mask (valid_mask),
      .victim_way (victim_way)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= '0;
      else        state_q <= state_d;
   end

   assign mru_bits   = state_q;
   assign victim_vld = lkp_req;

endmodule

// File: rtl/mru_repl_chk.sv
module mru_repl_chk #(
   parameter int unsigned WAYS = 12,
   parameter int unsigned WIDX = $clog2(WAYS)
) (
   input logic            clk,
   input logic            rst_n,
   input logic            acc_vld,
   input logic [WIDX-1:0] acc_way,
   input logic [WAYS-1:0] valid_mask,
   input logic            lkp_req,
   input logic            victim_vld,
   input logic [WIDX-1:0] victim_way,
   input logic [WAYS-1:0] mru_bits
);

   logic in_range;
   assign in_range = (int'(acc_way) < int'(WAYS));

   AST_RESET_ZERO: assert property (@(posedge clk) !rst_n |-> mru_bits == '0); // R1

   AST_ACCESS_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      acc_vld && in_range |=> mru_bits[$past(acc_way)]); // R2

   AST_WRAP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      acc_vld && in_range && ($countones(mru_bits) == WAYS - 1) && !mru_bits[acc_way]
      |=> $countones(mru_bits) == 1); // R3

   AST_NEVER_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(mru_bits) < WAYS); // R3

   AST_VICTIM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      lkp_req && (&valid_mask) |-> !mru_bits[victim_way]); // R4

   AST_INVALID_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      lkp_req && !(&valid_mask) |-> !valid_mask[victim_way]); // R5

   AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_vld || !in_range |=> $stable(mru_bits)); // R7

   AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      victim_vld == lkp_req); // R8

endmodule

bind mru_repl_set mru_repl_chk #(.WAYS(WAYS), .WIDX(WIDX)) i_chk (.*);

// File: tb/test_mru_repl_set.sv
`timescale 1ns/1ps
module test_mru_repl_set;

   localparam int W  = 12;
   localparam int WI = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          acc_vld = 1'b0;
   logic [WI-1:0] acc_way = '0;
   logic [W-1:0]  valid_mask = '1;
   logic          lkp_req = 1'b0;
   logic          victim_vld;
   logic [WI-1:0] victim_way;
   logic [W-1:0]  mru_bits;

   int n_chk = 0;
   int n_bad = 0;
   logic [W-1:0] ref_bits = '0;
   int tags [W];
   logic [W-1:0] tvld;

   always #2.5 clk = ~clk;

   mru_repl_set i_mru_repl_set (
      .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_way(acc_way),
      .valid_mask(valid_mask), .lkp_req(lkp_req), .victim_vld(victim_vld),
      .victim_way(victim_way), .mru_bits(mru_bits)
   );

   function automatic int ref_victim(input logic [W-1:0] bits, input logic [W-1:0] msk);
      if (msk != '1) begin
         for (int i = 0; i < W; i++) if (!msk[i]) return i;
      end
      for (int i = 0; i < W; i++) if (!bits[i]) return i;
      return 0;
   endfunction

   function automatic logic [W-1:0] ref_update(input logic [W-1:0] bits, input int way);
      logic [W-1:0] t;
      if (way >= W) return bits;
      t = bits;
      t[way] = 1'b1;
      if (t == '1) begin
         t = '0;
         t[way] = 1'b1;
      end
      return t;
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // One cycle: drive at negedge, compare outputs, then let the edge update the model.
   task automatic step(input bit acc, input int way, input logic [W-1:0] msk,
                       input bit qry, input string tag);
      @(negedge clk);
      acc_vld = acc; acc_way = WI'(way); valid_mask = msk; lkp_req = qry;
      #1;
      check(mru_bits == ref_bits, tag, int'(mru_bits), int'(ref_bits));
      if (qry)
         check(int'(victim_way) == ref_victim(ref_bits, msk),
               (msk == '1) ? "R4/R6" : "R5/R6", int'(victim_way), ref_victim(ref_bits, msk));
      check(victim_vld == qry, "R8", int'(victim_vld), int'(qry));
      @(posedge clk);
      if (acc) ref_bits = ref_update(ref_bits, way);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; acc_vld = 1'b0; lkp_req = 1'b1; valid_mask = '1;
      #1;
      check(mru_bits == '0, "R1", int'(mru_bits), 0);
      check(victim_way == '0, "R1", int'(victim_way), 0);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      ref_bits = '0;
      #1;
      check(mru_bits == '0, "R1", int'(mru_bits), 0);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      logic [15:0] lfsr;
      do_reset();

      // R2 and R3: sequential fill wraps on the final way.
      for (int i = 0; i < W; i++) step(1'b1, i, '1, 1'b1, "R2");
      @(negedge clk); #1;
      check(mru_bits == 12'h800, "R3", int'(mru_bits), 'h800);

      // R7: out-of-range indices and idle cycles.
      for (int i = W; i < 16; i++) step(1'b1, i, '1, 1'b0, "R7");
      step(1'b0, 3, '1, 1'b0, "R7");
      @(negedge clk); #1;
      check(mru_bits == 12'h800, "R7", int'(mru_bits), 'h800);

      // R6: lookup with simultaneous access to the current victim.
      step(1'b1, 0, '1, 1'b1, "R6");
      @(negedge clk); #1;
      check(victim_way == 4'd1, "R6", int'(victim_way), 1);

      // R5: holes in the valid mask override the flags.
      step(1'b0, 0, 12'b1111_1101_1111, 1'b1, "R5");
      step(1'b0, 0, 12'b0111_1111_1111, 1'b1, "R5");

      // Pseudo-random sweep over ways, masks and strobes.
      lfsr = 16'hACE1;
      for (int n = 0; n < 600; n++) begin
         logic [W-1:0] m;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         m = (lfsr[15:13] == 3'b000) ? ~(12'd1 << (lfsr[11:8] % W)) : '1;
         step(lfsr[4] | lfsr[6], int'(lfsr[3:0]), m, lfsr[7], "R2");
      end

      // R9: cyclic 13-address sweep through one set with a cache model.
      do_reset();
      tvld = '0;
      for (int i = 0; i < W; i++) tags[i] = -1;
      for (int n = 0; n < 13 * 40; n++) begin
         int addr, hw, vw;
         addr = n % 13;
         hw = -1;
         for (int i = 0; i < W; i++) if (tvld[i] && tags[i] == addr) hw = i;
         if (hw >= 0) begin
            step(1'b1, hw, tvld, 1'b0, "R9");
         end else begin
            vw = ref_victim(ref_bits, tvld);
            @(negedge clk); valid_mask = tvld; lkp_req = 1'b1; acc_vld = 1'b0; #1;
            check(int'(victim_way) == vw, "R9", int'(victim_way), vw);
            step(1'b1, vw, tvld, 1'b1, "R9");
            tags[vw] = addr;
            tvld[vw] = 1'b1;
         end
      end

      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule